// File: doc/BRIEF.md
# Pad Mode Control Multiplexer

This block is the per-pin control path of a sixteen-pin general-purpose port. For every pin it turns the stored configuration (a 2-bit mode, a drive-type bit, a 2-bit pull field and a 4-bit alternate-function selector) into the controls a pad cell needs. Those controls are output enable, output level, an open-drain flag, pull-up enable, pull-down enable and input-buffer enable. The speed field passes through to the pad untouched.

In the other direction, each pad level goes through a two-flop synchronizer. The synchronized level is delivered to the one alternate-function input that the pin's selector names, and it is also captured every cycle into a read-only input data register. Pins in analog mode have their input buffer off and read as 0. The configuration registers, the bus interface and the analog pad circuitry sit outside this block. The block only decodes and routes.

Top module: `gpm_pad_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the synchronizer stages and `in_data` clear to 0, so `in_data` reads 0 after reset whatever the pads show.
- R2: With mode code 01 (general output) and drive-type bit 0 (push-pull), `pad_oe` is 1 and `pad_do` equals the pin's bit of `out_data`.
- R3: With drive-type bit 1 in mode 01 or 10, `pad_od` is 1, `pad_do` is 0 and `pad_oe` is the inverse of the value to be driven, so only a low level is driven and a high level leaves the pad floating.
- R4: With mode code 10 (alternate function), the value driven is `af_out[p*16 + s]`, where s is the pin's selector.
- R5: Outside analog mode, pull code 01 sets `pad_pu` and pull code 10 sets `pad_pd`. Codes 00 and 11 set neither, and the two enables are never both 1.
- R6: With mode code 11 (analog), `pad_oe`, `pad_ie`, `pad_pu` and `pad_pd` are all 0, whatever the pull field holds.
- R7: Pin p (p<8) takes its selector from `cfg_af_lo[4p+3:4p]`, and pin p (p>=8) from `cfg_af_hi[4(p-8)+3:4(p-8)]`. The same selector picks the output source, and it places the synchronized pad level on `af_in[p*16 + s]` with every other bit of that pin's group at 0.
- R8: `in_data[p]` equals `pad_in[p]` three clock edges earlier when the pin is not analog, and 0 when it is analog.
- R9: `pad_speed` equals `cfg_speed` bit for bit.
- R10: With mode code 00 (input), `pad_oe` is 0 and `pad_ie` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 32 | 2-bit mode per pin, pin p at [2p+1:2p] |
| cfg_otype | input | 16 | Drive type per pin, 1 = open-drain |
| cfg_pull | input | 32 | 2-bit pull code per pin |
| cfg_speed | input | 32 | 2-bit speed per pin, passed through |
| cfg_af_lo | input | 32 | Alternate-function selectors, pins 0..7 |
| cfg_af_hi | input | 32 | Alternate-function selectors, pins 8..15 |
| out_data | input | 16 | Output data register value |
| af_out | input | 256 | Peripheral outputs, pin p function k at p*16+k |
| pad_in | input | 16 | Raw pad levels |
| pad_oe | output | 16 | Output driver enable |
| pad_do | output | 16 | Output level |
| pad_od | output | 16 | Open-drain drive in effect |
| pad_pu | output | 16 | Pull-up enable |
| pad_pd | output | 16 | Pull-down enable |
| pad_ie | output | 16 | Input buffer enable |
| pad_speed | output | 32 | Speed field to pad |
| af_in | output | 256 | Synchronized pad level to peripherals, pin p function k at p*16+k |
| in_data | output | 16 | Input data register |

## Verification
The bench targets the open-drain case with both output data levels. A design that drove the high level would show `pad_oe` set for a 1. It walks the selector through ascending and reversed assignments on both selector halves, so a swapped lo/hi source or a wrong nibble offset would route the wrong peripheral bit. It checks pull code 11 and pull codes under analog mode, where a naive decode would raise an enable. It also streams random pad levels through a mixed analog/input port, where a wrong synchronizer depth would shift the scoreboard by a cycle and a missing analog mask would leak pad levels into the register.

// File: rtl/gpm_pkg.sv
// Shared encodings for the pad mode control block.
// Assumes the 2-bit mode code is stored as given by the configuration registers.
package gpm_pkg;
    typedef enum logic [1:0] {
        MD_IN  = 2'b00,
        MD_GPO = 2'b01,
        MD_ALT = 2'b10,
        MD_ANA = 2'b11
    } pin_mode_e;

    localparam logic [1:0] PULL_UP   = 2'b01;
    localparam logic [1:0] PULL_DOWN = 2'b10;

    typedef struct packed {
        logic oe;
        logic dout;
        logic od;
        logic pu;
        logic pd;
        logic ie;
    } pad_ctl_t;
endpackage

// File: rtl/gpm_af_sel.sv
// One pin's alternate-function switch: a single selector picks which
// peripheral output drives the pin and which peripheral input sees the pin.
// Assumes in_bit is already synchronized to clk.
module gpm_af_sel #(
    parameter int NAF = 16,
    localparam int SW = $clog2(NAF)
) (
    input  logic [SW-1:0]  sel,
    input  logic [NAF-1:0] af_out,
    input  logic           in_bit,
    input  logic           in_en,
    output logic           af_val,
    output logic [NAF-1:0] af_in
);
    // Output side: pick the selected peripheral output.
    always_comb af_val = af_out[sel];

    // Input side: demultiplex the pad level to the selected peripheral only.
    always_comb begin
        af_in      = '0;
        af_in[sel] = in_bit & in_en;
    end
endmodule

// File: rtl/gpm_drive_dec.sv
// Decodes one pin's mode, drive type and pull code into pad controls.
// Assumes af_val is the already selected alternate-function output.
module gpm_drive_dec
    import gpm_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       otype,
    input  logic [1:0] pull,
    input  logic       odata,
    input  logic       af_val,
    output pad_ctl_t   ctl
);
    logic drv;
    logic active;

    // Select the drive source and whether the driver is in use at all.
    always_comb begin
        active = (mode == MD_GPO) || (mode == MD_ALT);
        drv    = (mode == MD_ALT) ? af_val : odata;
    end

    // Build the pad controls; open-drain only ever drives a low level.
    always_comb begin
        ctl    = '0;
        ctl.ie = (mode != MD_ANA);
        if (active) begin
            if (otype) begin
                ctl.od   = 1'b1;
                ctl.oe   = ~drv;
                ctl.dout = 1'b0;
            end else begin
                ctl.oe   = 1'b1;
                ctl.dout = drv;
            end
        end
        ctl.pu = (mode != MD_ANA) && (pull == PULL_UP);
        ctl.pd = (mode != MD_ANA) && (pull == PULL_DOWN);
    end
endmodule

// File: rtl/gpm_in_sync.sv
// Two-flop synchronizer per pad followed by the input data register.
// Assumes pad_in is asynchronous to clk; ie masks pins with the buffer off.
module gpm_in_sync #(
    parameter int NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pad_in,
    input  logic [NPIN-1:0] ie,
    output logic [NPIN-1:0] sync_q,
    output logic [NPIN-1:0] in_data
);
    logic [NPIN-1:0] s1;

    // Synchronize the pads and capture the masked level every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1      <= '0;
            sync_q  <= '0;
            in_data <= '0;
        end else begin
            s1      <= pad_in;
            sync_q  <= s1;
            in_data <= sync_q & ie;
        end
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_chk
        AST_IDR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            !ie[i] |=> !in_data[i]); // R8
    end
endmodule

// File: rtl/gpm_pad_ctrl.sv
// Pad mode control multiplexer for a port of NPIN pins.
// Per pin: decodes mode/drive type/pull into pad controls, routes one of NAF
// alternate functions both ways, and samples pads into an input register.
// Assumes configuration inputs are static registers in the clk domain.
module gpm_pad_ctrl
    import gpm_pkg::*;
#(
    parameter int NPIN = 16,
    parameter int NAF  = 16,
    localparam int SW   = $clog2(NAF),
    localparam int LO_N = NPIN / 2,
    localparam int HI_N = NPIN - LO_N
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*NPIN-1:0]   cfg_mode,
    input  logic [NPIN-1:0]     cfg_otype,
    input  logic [2*NPIN-1:0]   cfg_pull,
    input  logic [2*NPIN-1:0]   cfg_speed,
    input  logic [LO_N*SW-1:0]  cfg_af_lo,
    input  logic [HI_N*SW-1:0]  cfg_af_hi,
    input  logic [NPIN-1:0]     out_data,
    input  logic [NPIN*NAF-1:0] af_out,
    input  logic [NPIN-1:0]     pad_in,
    output logic [NPIN-1:0]     pad_oe,
    output logic [NPIN-1:0]     pad_do,
    output logic [NPIN-1:0]     pad_od,
    output logic [NPIN-1:0]     pad_pu,
    output logic [NPIN-1:0]     pad_pd,
    output logic [NPIN-1:0]     pad_ie,
    output logic [2*NPIN-1:0]   pad_speed,
    output logic [NPIN*NAF-1:0] af_in,
    output logic [NPIN-1:0]     in_data
);
    logic [NPIN-1:0] sync_q;

    // Speed field is not interpreted here.
    always_comb pad_speed = cfg_speed;

    gpm_in_sync #(.NPIN(NPIN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_in  (pad_in),
        .ie      (pad_ie),
        .sync_q  (sync_q),
        .in_data (in_data)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [SW-1:0] sel;
        logic          af_val;
        pad_ctl_t      ctl;

        if (p < LO_N) begin : g_lo
            always_comb sel = cfg_af_lo[p*SW +: SW];
        end else begin : g_hi
            always_comb sel = cfg_af_hi[(p-LO_N)*SW +: SW];
        end

        gpm_af_sel #(.NAF(NAF)) u_af (
            .sel    (sel),
            .af_out (af_out[p*NAF +: NAF]),
            .in_bit (sync_q[p]),
            .in_en  (ctl.ie),
            .af_val (af_val),
            .af_in  (af_in[p*NAF +: NAF])
        );

        gpm_drive_dec u_dec (
            .mode   (cfg_mode[2*p +: 2]),
            .otype  (cfg_otype[p]),
            .pull   (cfg_pull[2*p +: 2]),
            .odata  (out_data[p]),
            .af_val (af_val),
            .ctl    (ctl)
        );

        // Unpack the per-pin control struct onto the port vectors.
        always_comb begin
            pad_oe[p] = ctl.oe;
            pad_do[p] = ctl.dout;
            pad_od[p] = ctl.od;
            pad_pu[p] = ctl.pu;
            pad_pd[p] = ctl.pd;
            pad_ie[p] = ctl.ie;
        end

        AST_GPO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_mode[2*p +: 2] == MD_GPO && !cfg_otype[p]) |-> (pad_oe[p] && pad_do[p] == out_data[p])); // R2
        AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_od[p] && pad_oe[p]) |-> !pad_do[p]); // R3
        AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
            !(pad_pu[p] && pad_pd[p])); // R5
        AST_ANALOG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_mode[2*p +: 2] == MD_ANA) |-> !(pad_oe[p] || pad_ie[p] || pad_pu[p] || pad_pd[p])); // R6
        AST_AF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(af_in[p*NAF +: NAF])); // R7
        AST_INPUT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_mode[2*p +: 2] == MD_IN) |-> (!pad_oe[p] && pad_ie[p])); // R10
    end
endmodule

// File: tb/tb_gpm_pad_ctrl.sv
module tb_gpm_pad_ctrl;
    localparam int NP = 16;
    localparam int NA = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2*NP-1:0] cfg_mode = '1, cfg_pull = '0, cfg_speed = '0;
    logic [NP-1:0]   cfg_otype = '0, out_data = '0, pad_in = '0;
    logic [31:0]     cfg_af_lo = '0, cfg_af_hi = '0;
    logic [NP*NA-1:0] af_out = '0;
    logic [NP-1:0]   pad_oe, pad_do, pad_od, pad_pu, pad_pd, pad_ie, in_data;
    logic [2*NP-1:0] pad_speed;
    logic [NP*NA-1:0] af_in;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;
    bit mon_on = 0;

    typedef struct { int stamp; logic [15:0] val; } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gpm_pad_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_otype(cfg_otype),
        .cfg_pull(cfg_pull), .cfg_speed(cfg_speed), .cfg_af_lo(cfg_af_lo),
        .cfg_af_hi(cfg_af_hi), .out_data(out_data), .af_out(af_out),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do), .pad_od(pad_od),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ie(pad_ie),
        .pad_speed(pad_speed), .af_in(af_in), .in_data(in_data)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Monitor: pops scoreboard items once three edges have passed (R8).
    always @(negedge clk) begin
        if (mon_on) begin
            while (q.size() > 0 && q[0].stamp + 3 <= cyc) begin
                exp_t e;
                e = q.pop_front();
                check("R8 in_data", {16'h0, in_data}, {16'h0, e.val});
            end
        end
    end

    task automatic set_all(logic [1:0] m, logic ot, logic [1:0] pl);
        for (int p = 0; p < NP; p++) begin
            cfg_mode[2*p +: 2] = m;
            cfg_pull[2*p +: 2] = pl;
            cfg_otype[p] = ot;
        end
    endtask

    task automatic set_sel(int p, logic [3:0] s);
        if (p < 8) cfg_af_lo[4*p +: 4] = s;
        else       cfg_af_hi[4*(p-8) +: 4] = s;
    endtask

    // Build af_out so the selected function carries pat, all others its inverse.
    task automatic load_af(logic [15:0] pat, bit rev);
        for (int p = 0; p < NP; p++) begin
            int s;
            s = rev ? 15 - p : p;
            set_sel(p, 4'(s));
            for (int k = 0; k < NA; k++)
                af_out[p*NA + k] = (k == s) ? pat[p] : ~pat[p];
        end
    endtask

    initial begin
        logic [15:0] pat, exp_pu, exp_pd;
        pad_in = 16'hFFFF;
        repeat (4) @(negedge clk);
        check("R1 reset in_data", {16'h0, in_data}, 32'h0);
        rst_n = 1'b1;

        // R2 push-pull output
        @(negedge clk);
        set_all(2'b01, 1'b0, 2'b00);
        out_data = 16'hA5C3;
        #1;
        check("R2 oe", {16'h0, pad_oe}, 32'hFFFF);
        check("R2 do", {16'h0, pad_do}, 32'hA5C3);
        check("R3 od flag clear", {16'h0, pad_od}, 32'h0);

        // R3 open-drain output
        @(negedge clk);
        set_all(2'b01, 1'b1, 2'b00);
        #1;
        check("R3 oe", {16'h0, pad_oe}, {16'h0, ~16'hA5C3});
        check("R3 do", {16'h0, pad_do}, 32'h0);
        check("R3 od", {16'h0, pad_od}, 32'hFFFF);

        // R4/R7 alternate function drive, ascending then reversed selectors
        @(negedge clk);
        set_all(2'b10, 1'b0, 2'b00);
        pat = 16'h6E19;
        load_af(pat, 0);
        #1;
        check("R4 af do asc", {16'h0, pad_do}, {16'h0, pat});
        check("R4 af oe", {16'h0, pad_oe}, 32'hFFFF);
        @(negedge clk);
        pat = 16'h93B4;
        load_af(pat, 1);
        #1;
        check("R7 af do rev", {16'h0, pad_do}, {16'h0, pat});
        @(negedge clk);
        cfg_otype = '1;
        #1;
        check("R3 af od oe", {16'h0, pad_oe}, {16'h0, ~pat});

        // R5 pull decode in input mode, codes cycling 00,01,10,11
        @(negedge clk);
        set_all(2'b00, 1'b0, 2'b00);
        exp_pu = '0; exp_pd = '0;
        for (int p = 0; p < NP; p++) begin
            cfg_pull[2*p +: 2] = 2'(p % 4);
            exp_pu[p] = (p % 4 == 1);
            exp_pd[p] = (p % 4 == 2);
        end
        #1;
        check("R5 pu", {16'h0, pad_pu}, {16'h0, exp_pu});
        check("R5 pd", {16'h0, pad_pd}, {16'h0, exp_pd});
        check("R10 oe", {16'h0, pad_oe}, 32'h0);
        check("R10 ie", {16'h0, pad_ie}, 32'hFFFF);

        // R6 analog ignores pull code
        @(negedge clk);
        cfg_mode = '1;
        cfg_pull = 32'h5555_5555;
        #1;
        check("R6 pu", {16'h0, pad_pu}, 32'h0);
        check("R6 oe", {16'h0, pad_oe}, 32'h0);
        check("R6 ie", {16'h0, pad_ie}, 32'h0);
        cfg_pull = 32'hAAAA_AAAA;
        #1;
        check("R6 pd", {16'h0, pad_pd}, 32'h0);

        // R9 speed passthrough
        cfg_speed = 32'hC3A5_1E77;
        #1;
        check("R9 speed", pad_speed, 32'hC3A5_1E77);

        // R7 alternate-function input routing
        @(negedge clk);
        set_all(2'b10, 1'b0, 2'b00);
        for (int p = 0; p < NP; p++) set_sel(p, 4'((p * 5) % 16));
        pad_in = 16'h3C96;
        repeat (3) @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            logic [15:0] ev;
            ev = '0;
            ev[(p * 5) % 16] = pad_in[p];
            check("R7 af_in", {16'h0, af_in[p*NA +: NA]}, {16'h0, ev});
        end

        // R8 scoreboard stream: even pins analog, odd pins input
        for (int p = 0; p < NP; p++) cfg_mode[2*p +: 2] = (p % 2 == 0) ? 2'b11 : 2'b00;
        repeat (4) @(negedge clk);
        mon_on = 1;
        for (int i = 0; i < 40; i++) begin
            exp_t e;
            @(negedge clk);
            pad_in = 16'($urandom);
            e.stamp = cyc;
            e.val = pad_in & 16'hAAAA;
            q.push_back(e);
        end
        repeat (5) @(negedge clk);
        mon_on = 0;
        check("R8 queue drained", q.size(), 0);
        done = 1;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=done");
        end
    end

    initial begin
        wait (done || cyc >= 20000);
        #2;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule